// File: doc/BRIEF.md
# Port Control Set/Clear Register

This block is the control and status word of one storage host adapter port, reached over a simple 32-bit memory-mapped register bus. Software never writes the word directly. One address sets every control bit written as one, and a second address clears every control bit written as one. A read of the set address returns a status view, in which some bits reflect sequences in progress and the top bit reports that the port can accept commands.

Three sequences are modelled. The port reset is a level that stays asserted until software clears it. The device reset starts on request and clears itself. The initialise sequence also clears itself, and it is the only way the port-ready flag rises. The physical link, the link layer and the command engine are not part of the block. A stub engine stands in for them: it sees a request level from the block and returns a one-cycle done pulse. A sequence completes a fixed, parameterised settle time after that pulse. The persistent control bits drive outputs towards the link and the command engine.

Top module: `port_ctrl_block`

## Requirements
- R1: A write to the set address (default 0x1000) turns on every persistent control bit whose data bit is one. Bits written as zero keep their value, and the word stays unchanged in every cycle without a write. The persistent bits are: port reset bit 0, interrupt write-one-to-clear bit 3, 16-byte packet command length bit 5, resume bit 6, 32-bit activation bit 10, port-multiplier enable bit 13.
- R2: A write to the clear address (default 0x1004) turns off every persistent control bit whose data bit is one. Bits written as zero keep their value.
- R3: A read of the set address returns the status view: the persistent bits at their positions, bit 1 set while a device reset runs, bit 2 set while an initialise runs, and bit 31 as port-ready. All other bits read zero and ignore writes. Any other read address returns zero.
- R4: Port reset stays asserted until it is cleared through the clear address. While it is asserted, ready reads zero. Device-reset and initialise requests are ignored while it is asserted or while they are written together with it.
- R5: Setting bit 1 starts a device reset. Bit 1 and the engine device request read one from the cycle after the write. Bit 1 returns to zero exactly SETTLE cycles after the clock edge that samples the engine done pulse.
- R6: Setting bit 2 starts an initialise. Bit 2 and the engine initialise request read one until completion. Bit 31 rises exactly SETTLE cycles after the edge that samples the done pulse, and only as the result of an initialise completing.
- R7: Starting a device reset clears ready. Ready is still zero after the device reset completes, and a later initialise brings it back.
- R8: A set-address write with bit 0 set aborts a running device reset or initialise. In the next cycle, bits 1, 2 and 31 and both engine requests read zero.
- R9: Only one sequence runs at a time. A request that arrives while a sequence is running is ignored. When bits 1 and 2 are written together, device reset wins. Clear-address writes to bits 1 and 2 have no effect.
- R10: The outputs port_rst_o, irq_woc_o, cdb16_o, resume_o, act32_o, pm_en_o and ready_o follow the corresponding status bits.
- R11: An engine done pulse while no sequence is waiting has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data (set or clear mask) |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| eng_done | input | 1 | Done pulse from the stub engine |
| eng_dev_req | output | 1 | Device reset waiting for the engine |
| eng_init_req | output | 1 | Initialise waiting for the engine |
| port_rst_o | output | 1 | Port reset level |
| irq_woc_o | output | 1 | Interrupt write-one-to-clear select |
| cdb16_o | output | 1 | 16-byte packet command length select |
| resume_o | output | 1 | Resume control |
| act32_o | output | 1 | 32-bit activation enable |
| pm_en_o | output | 1 | Port-multiplier enable |
| ready_o | output | 1 | Port ready for commands |

## Verification
A single one is walked through all 32 positions on the set address and then on the clear address. This separates the persistent bits from the reserved bits and shows that each address acts only on its own bit. Dense all-ones masks and mixed masks show that zero bits leave the state alone. The sequences are driven with a done pulse and counted cycle by cycle: the last busy cycle and the first finished cycle are both checked, which separates a correct settle time from one cycle too short or too long. Collision patterns are also applied: an abort in mid-settle, both request bits in one write, a request while busy, and requests while the port is in reset. These separate the priority rules from one another.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int REG_W     = 32;
  localparam int PB_PRST   = 0;
  localparam int PB_DRST   = 1;
  localparam int PB_INIT   = 2;
  localparam int PB_WOC    = 3;
  localparam int PB_CDB16  = 5;
  localparam int PB_RESUME = 6;
  localparam int PB_ACT32  = 10;
  localparam int PB_PMEN   = 13;
  localparam int PB_RDY    = 31;

  localparam logic [REG_W-1:0] PERSIST_MASK =
    (REG_W'(1) << PB_PRST)   | (REG_W'(1) << PB_WOC)   |
    (REG_W'(1) << PB_CDB16)  | (REG_W'(1) << PB_RESUME) |
    (REG_W'(1) << PB_ACT32)  | (REG_W'(1) << PB_PMEN);

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_DEV_WAIT, SQ_DEV_SETTLE, SQ_INI_WAIT, SQ_INI_SETTLE
  } seq_state_t;

  // apply one bus write to the persistent word
  function automatic logic [REG_W-1:0] apply_write(
    input logic [REG_W-1:0] cur, input logic [REG_W-1:0] data,
    input logic do_set, input logic do_clr);
    logic [REG_W-1:0] m;
    m = data & PERSIST_MASK;
    if (do_set)      return cur | m;
    else if (do_clr) return cur & ~m;
    else             return cur;
  endfunction

  // compose the status view
  function automatic logic [REG_W-1:0] status_word(
    input logic [REG_W-1:0] ctrl, input logic dev_busy,
    input logic init_busy, input logic rdy);
    logic [REG_W-1:0] s;
    s = ctrl & PERSIST_MASK;
    s[PB_DRST] = dev_busy;
    s[PB_INIT] = init_busy;
    s[PB_RDY]  = rdy;
    return s;
  endfunction
endpackage

// File: rtl/pcr_decode.sv
module pcr_decode #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] SET_OFS = 13'h1000,
  parameter logic [ADDR_W-1:0] CLR_OFS = 13'h1004
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              set_stb,
  output logic              clr_stb,
  output logic              rd_hit
);
  assign set_stb = wr_en && (wr_addr == SET_OFS);
  assign clr_stb = wr_en && (wr_addr == CLR_OFS);
  assign rd_hit  = (rd_addr == SET_OFS);
endmodule

// File: rtl/pcr_ctrl_bits.sv
module pcr_ctrl_bits
  import pcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ctrl_q
);
  logic [REG_W-1:0] ctrl_d;
  assign ctrl_d = apply_write(ctrl_q, wdata, set_stb, clr_stb);

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (PERSIST_MASK[b]) begin : g_ff
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= ctrl_d[b];
      end
      assign ctrl_q[b] = q;
    end else begin : g_zero
      assign ctrl_q[b] = 1'b0;
    end
  end

  AST_SET_PMEN: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb && wdata[PB_PMEN] |=> ctrl_q[PB_PMEN]); // R1
  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !set_stb && !clr_stb |=> $stable(ctrl_q)); // R1
  AST_CLR_PMEN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb && wdata[PB_PMEN] |=> !ctrl_q[PB_PMEN]); // R2
endmodule

// File: rtl/pcr_seq.sv
module pcr_seq
  import pcr_pkg::*;
#(
  parameter int SETTLE = 16,
  localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_req,
  input  logic init_req,
  input  logic abort,
  input  logic eng_done,
  output logic dev_busy,
  output logic init_busy,
  output logic eng_dev_req,
  output logic eng_init_req,
  output logic seq_start,
  output logic dev_fin,
  output logic init_fin
);
  seq_state_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE - 1);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    dev_fin   = 1'b0;
    init_fin  = 1'b0;
    seq_start = 1'b0;
    if (abort) begin
      st_d  = SQ_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          if (dev_req)       begin st_d = SQ_DEV_WAIT; seq_start = 1'b1; end
          else if (init_req) begin st_d = SQ_INI_WAIT; seq_start = 1'b1; end
        end
        SQ_DEV_WAIT: if (eng_done) begin st_d = SQ_DEV_SETTLE; cnt_d = CNT_LOAD; end
        SQ_INI_WAIT: if (eng_done) begin st_d = SQ_INI_SETTLE; cnt_d = CNT_LOAD; end
        SQ_DEV_SETTLE: begin
          if (cnt_q == '0) begin st_d = SQ_IDLE; dev_fin = 1'b1; end
          else cnt_d = cnt_q - 1'b1;
        end
        SQ_INI_SETTLE: begin
          if (cnt_q == '0) begin st_d = SQ_IDLE; init_fin = 1'b1; end
          else cnt_d = cnt_q - 1'b1;
        end
        default: st_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign dev_busy     = (st_q == SQ_DEV_WAIT) || (st_q == SQ_DEV_SETTLE);
  assign init_busy    = (st_q == SQ_INI_WAIT) || (st_q == SQ_INI_SETTLE);
  assign eng_dev_req  = (st_q == SQ_DEV_WAIT);
  assign eng_init_req = (st_q == SQ_INI_WAIT);

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !dev_busy && !init_busy); // R8
  AST_ONE_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_busy, init_busy})); // R9
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_INI_SETTLE || st_q == SQ_DEV_SETTLE) |-> (int'(cnt_q) < SETTLE)); // R6
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_IDLE) && eng_done && !dev_req && !init_req |=> st_q == SQ_IDLE); // R11
endmodule

// File: rtl/port_ctrl_block.sv
module port_ctrl_block
  import pcr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] SET_OFS = 13'h1000,
  parameter logic [ADDR_W-1:0] CLR_OFS = 13'h1004,
  parameter int SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              eng_done,
  output logic              eng_dev_req,
  output logic              eng_init_req,
  output logic              port_rst_o,
  output logic              irq_woc_o,
  output logic              cdb16_o,
  output logic              resume_o,
  output logic              act32_o,
  output logic              pm_en_o,
  output logic              ready_o
);
  logic set_stb, clr_stb, rd_hit;
  logic [REG_W-1:0] ctrl_q;
  logic abort, dev_req, init_req;
  logic dev_busy, init_busy, seq_start, dev_fin, init_fin;
  logic rdy_q;

  pcr_decode #(.ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .set_stb(set_stb), .clr_stb(clr_stb), .rd_hit(rd_hit));

  pcr_ctrl_bits u_bits (
    .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
    .wdata(wr_data), .ctrl_q(ctrl_q));

  // port reset in the same write, or already held, blocks new sequences
  assign abort    = set_stb && wr_data[PB_PRST];
  assign dev_req  = set_stb && wr_data[PB_DRST] && !wr_data[PB_PRST] && !ctrl_q[PB_PRST];
  assign init_req = set_stb && wr_data[PB_INIT] && !wr_data[PB_PRST] && !ctrl_q[PB_PRST];

  pcr_seq #(.SETTLE(SETTLE)) u_seq (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .init_req(init_req),
    .abort(abort), .eng_done(eng_done), .dev_busy(dev_busy),
    .init_busy(init_busy), .eng_dev_req(eng_dev_req),
    .eng_init_req(eng_init_req), .seq_start(seq_start),
    .dev_fin(dev_fin), .init_fin(init_fin));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rdy_q <= 1'b0;
    else if (abort || seq_start) rdy_q <= 1'b0;
    else if (init_fin)           rdy_q <= 1'b1;
  end

  assign rd_data    = rd_hit ? status_word(ctrl_q, dev_busy, init_busy, rdy_q) : '0;
  assign port_rst_o = ctrl_q[PB_PRST];
  assign irq_woc_o  = ctrl_q[PB_WOC];
  assign cdb16_o    = ctrl_q[PB_CDB16];
  assign resume_o   = ctrl_q[PB_RESUME];
  assign act32_o    = ctrl_q[PB_ACT32];
  assign pm_en_o    = ctrl_q[PB_PMEN];
  assign ready_o    = rdy_q;

  AST_RDY_LOW_IN_RST: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_o |-> !ready_o); // R4
  AST_RDY_FROM_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(init_fin)); // R6
  AST_DEV_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fin |=> !ready_o); // R7
endmodule

// File: tb/sim_port_ctrl_block.sv
`timescale 1ns/1ps
module sim_port_ctrl_block;
  localparam int S = 16;
  localparam logic [12:0] SET_A = 13'h1000;
  localparam logic [12:0] CLR_A = 13'h1004;
  localparam logic [31:0] PM = 32'h0000_2469;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, eng_done = 1'b0;
  logic [12:0] wr_addr = '0, rd_addr = SET_A;
  logic [31:0] wr_data = '0, rd_data;
  logic eng_dev_req, eng_init_req, port_rst_o, irq_woc_o, cdb16_o;
  logic resume_o, act32_o, pm_en_o, ready_o;
  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] m_ctrl = '0;
  logic m_dev = 0, m_init = 0, m_rdy = 0;

  always #2 clk = ~clk;

  port_ctrl_block #(.SETTLE(S)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .eng_done(eng_done), .eng_dev_req(eng_dev_req), .eng_init_req(eng_init_req),
    .port_rst_o(port_rst_o), .irq_woc_o(irq_woc_o), .cdb16_o(cdb16_o),
    .resume_o(resume_o), .act32_o(act32_o), .pm_en_o(pm_en_o), .ready_o(ready_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_stat();
    return (m_ctrl & PM) | (32'(m_dev) << 1) | (32'(m_init) << 2) | (32'(m_rdy) << 31);
  endfunction

  function automatic logic [31:0] exp_pins();
    return {25'd0, m_rdy, m_ctrl[13], m_ctrl[10], m_ctrl[6], m_ctrl[5], m_ctrl[3], m_ctrl[0]};
  endfunction

  function automatic logic [31:0] pins();
    return {25'd0, ready_o, pm_en_o, act32_o, resume_o, cdb16_o, irq_woc_o, port_rst_o};
  endfunction

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset status", rd_data, 32'h0);
    chk("R10 reset pins", {30'd0, eng_dev_req, eng_init_req} | pins(), 32'h0);

    // walking one on set then clear address
    for (int i = 0; i < 32; i++) begin
      if (i == 1 || i == 2) continue;
      wr(SET_A, 32'h1 << i);
      m_ctrl = m_ctrl | ((32'h1 << i) & PM);
      chk($sformatf("R1 set bit %0d", i), rd_data, exp_stat());
      chk($sformatf("R10 pins after set %0d", i), pins(), exp_pins());
      wr(CLR_A, 32'h1 << i);
      m_ctrl = m_ctrl & ~(32'h1 << i);
      chk($sformatf("R2 clear bit %0d", i), rd_data, exp_stat());
    end

    wr(SET_A, 32'hFFFF_FFF9); m_ctrl = PM;
    chk("R1 dense set", rd_data, exp_stat());
    chk("R10 dense pins", pins(), exp_pins());
    chk("R4 ready low in reset", 32'(ready_o), 32'h0);
    wr(CLR_A, 32'h0000_0009); m_ctrl = PM & ~32'h9;
    chk("R2 partial clear keeps others", rd_data, exp_stat());
    rd_addr = CLR_A; #0.1;
    chk("R3 clear address reads zero", rd_data, 32'h0);
    rd_addr = 13'h0008; #0.1;
    chk("R3 other address reads zero", rd_data, 32'h0);
    rd_addr = SET_A;
    wr(CLR_A, 32'hFFFF_FFFF); m_ctrl = 0;
    chk("R2 clear all", rd_data, exp_stat());

    // done while idle
    done_pulse();
    chk("R11 idle done ignored", rd_data, exp_stat());

    // initialise
    wr(SET_A, 32'h4); m_init = 1;
    chk("R6 init busy", rd_data, exp_stat());
    chk("R6 init request", 32'(eng_init_req), 32'h1);
    wr(SET_A, 32'h2);
    chk("R9 dev req while busy ignored", rd_data, exp_stat());
    done_pulse();
    repeat (S-1) @(negedge clk);
    chk("R6 last settle cycle", rd_data, exp_stat());
    @(negedge clk); m_init = 0; m_rdy = 1;
    chk("R6 ready after settle", rd_data, exp_stat());
    chk("R10 ready pin", pins(), exp_pins());

    // device reset
    wr(SET_A, 32'h2); m_dev = 1; m_rdy = 0;
    chk("R7 dev start clears ready", rd_data, exp_stat());
    chk("R5 dev request", 32'(eng_dev_req), 32'h1);
    wr(CLR_A, 32'h6);
    chk("R9 clear of seq bits ignored", rd_data, exp_stat());
    wr(SET_A, 32'h4);
    chk("R9 init while dev busy ignored", rd_data, exp_stat());
    done_pulse();
    repeat (S-1) @(negedge clk);
    chk("R5 dev last settle cycle", rd_data, exp_stat());
    @(negedge clk); m_dev = 0;
    chk("R5 dev self clears", rd_data, exp_stat());
    chk("R7 ready still low", 32'(ready_o), 32'h0);

    // both requests in one write
    wr(SET_A, 32'h6); m_dev = 1;
    chk("R9 dev wins", rd_data, exp_stat());
    done_pulse(); repeat (S) @(negedge clk); m_dev = 0;
    chk("R5 dev done again", rd_data, exp_stat());

    // init to ready, then port reset drops ready
    wr(SET_A, 32'h4); done_pulse(); repeat (S) @(negedge clk);
    m_rdy = 1;
    chk("R7 init after dev reset gives ready", rd_data, exp_stat());
    wr(SET_A, 32'h1); m_ctrl = 1; m_rdy = 0;
    chk("R4 port reset clears ready", rd_data, exp_stat());
    wr(SET_A, 32'h6);
    chk("R4 requests ignored in reset", rd_data, exp_stat());
    chk("R4 no engine request", {30'd0, eng_dev_req, eng_init_req}, 32'h0);
    wr(CLR_A, 32'h1); m_ctrl = 0;

    // abort mid settle
    wr(SET_A, 32'h4); done_pulse(); repeat (3) @(negedge clk);
    wr(SET_A, 32'h1); m_ctrl = 1;
    chk("R8 abort init", rd_data, exp_stat());
    repeat (S) @(negedge clk);
    chk("R8 no late ready", rd_data, exp_stat());
    wr(CLR_A, 32'h1); m_ctrl = 0;
    wr(SET_A, 32'h2);
    wr(SET_A, 32'h5); m_ctrl = 1;
    chk("R8 abort dev waiting", rd_data, exp_stat());
    chk("R8 requests dropped", {30'd0, eng_dev_req, eng_init_req}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule